// File: doc/BRIEF.md
# Wavefront Atomic Operation Coalescer

The block takes the atomic operations that the lanes of one wavefront raise together in a single instruction and folds every lane that targets the same 32-bit word into one memory request. Each request carries the word address and a lane mask. The mask gives the ordered list of operations: the marked lanes are applied in ascending lane index. Memory answers each request once, with the word's starting value. The block then replays the marked lanes' operations one after another on that value. Each lane that wants a result gets the value the word held just before its own operation. After the replay, the block writes the final word back.

Distinct addresses become separate requests. The group whose lowest lane index is smallest goes first, and only one request is outstanding at any time. When every group has been replayed, a one-cycle `done` marks the per-lane result vector as complete. The results stay on the outputs until the next `start`.

The controller is a seven-state machine:
- IDLE waits for `start`. On `start` it captures the lane vectors, clears the results and moves to PICK.
- PICK looks for the lowest pending lane. If one is found, it forms that lane's address group and goes to REQ. If none is left, it goes to DONE.
- REQ holds the request until `mem_req_rdy`, then goes to WAIT.
- WAIT holds until `mem_rsp_vld`, then loads the starting value and goes to APPLY.
- APPLY visits one lane index per cycle and goes to WBACK after the last index.
- WBACK emits the write-back for one cycle and returns to PICK.
- DONE pulses `done` for one cycle and returns to IDLE.

Top module: `atomic_coalescer`

## Requirements
- R1: Each distinct word address among the valid lanes produces exactly one memory request. Its `mem_req_mask` marks exactly the valid lanes that carry that address.
- R2: Requests are issued in order of their lowest lane index. A new request appears only after the response to the previous one has arrived. Address and mask hold steady while the request waits for `mem_req_rdy`.
- R3: Lanes sharing an address are applied in ascending lane index. A lane that wants a result receives the word's value just before its own operation, so the lowest lane of a group receives the value returned by memory.
- R4: Opcode field (3 bits per lane) encoding:
  - 0: wrapping add of operand A.
  - 1: unsigned minimum with operand A.
  - 2: unsigned maximum with operand A.
  - 3: exchange, which writes operand A.
  - 4: compare-swap, which writes operand A only if the word equals operand B and otherwise leaves it unchanged.
  - 5 to 7: leave the word unchanged.
- R5: After each response, exactly one write-back pulse (`wb_vld`) carries the group's address and the value obtained by applying all of the group's operations in order.
- R6: A valid lane with `lane_ret` low still takes part in the final value, but its `res_vld` stays low and its `res_data` stays zero.
- R7: Lanes with `lane_vld` low have no effect on any request, write-back or result. Their `res_vld` is low and their `res_data` is zero.
- R8: `done` is a single-cycle pulse raised after every group has been written back. With no valid lane it comes without any request. Results hold after `done` until the next `start`.
- R9: After reset the block is idle: `busy`, `mem_req_vld`, `wb_vld`, `done` and all `res_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture lane vectors and begin (ignored while busy) |
| lane_vld | input | LANES | Lane takes part |
| lane_ret | input | LANES | Lane wants a return value |
| lane_addr | input | LANES*AW | Per-lane word address |
| lane_op | input | LANES*3 | Per-lane opcode |
| lane_opa | input | LANES*DW | Per-lane operand A |
| lane_opb | input | LANES*DW | Per-lane operand B (compare value) |
| busy | output | 1 | Block is not idle |
| mem_req_vld | output | 1 | Merged request valid |
| mem_req_rdy | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Word address of the request |
| mem_req_mask | output | LANES | Lanes merged into the request, applied in ascending order |
| mem_rsp_vld | input | 1 | Response valid |
| mem_rsp_data | input | DW | Starting value of the word |
| wb_vld | output | 1 | Final value write-back pulse |
| wb_addr | output | AW | Write-back address |
| wb_data | output | DW | Final word value |
| done | output | 1 | All groups processed |
| res_vld | output | LANES | Per-lane result valid |
| res_data | output | LANES*DW | Per-lane pre-operation value |

## Verification
The bench sweeps every opcode, including the three unused codes, over crowded address sets where many lanes collide on one word.

One class of fault is a coalescer that hands each lane the merged final value, or replays a group in the wrong order. It would return the same value to every lane of a group, and the bench would see the wrong prefix values. Another class is faulty grouping: a wrong match or a mask that leaks across addresses would issue extra or missing requests, or groups in the wrong sequence. The bench compares every request against its own list of expected groups.

Compare-swap chains, where a later lane's compare depends on an earlier lane's swap, expose a wrong choice of operand or a misplaced compare. Lanes with the return flag off, invalid lanes and an empty wavefront catch results that leak into lanes that should stay at zero, and a `done` that never comes.

// File: rtl/aco_pkg.sv
package aco_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_UMIN = 3'd1,
        OP_UMAX = 3'd2,
        OP_XCHG = 3'd3,
        OP_CAS  = 3'd4
    } aco_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_REQ,
        S_WAIT,
        S_APPLY,
        S_WBACK,
        S_DONE
    } aco_state_e;

    localparam int OPW = 3;

endpackage

// File: rtl/aco_alu.sv
module aco_alu #(
    parameter int DW = 32
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] new_val
);
    import aco_pkg::*;

    always_comb begin
        new_val = old_val;
        case (op)
            OP_ADD:  new_val = old_val + opa;
            OP_UMIN: new_val = (opa < old_val) ? opa : old_val;
            OP_UMAX: new_val = (opa > old_val) ? opa : old_val;
            OP_XCHG: new_val = opa;
            OP_CAS:  new_val = (old_val == opb) ? opa : old_val;
            default: new_val = old_val;
        endcase
    end

endmodule

// File: rtl/aco_group_pick.sv
module aco_group_pick #(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*AW-1:0] addr,
    output logic                found,
    output logic [AW-1:0]       lead_addr,
    output logic [LANES-1:0]    grp_mask
);
    logic [AW-1:0] lead_addr_c;

    // lowest pending lane sets the group address
    always_comb begin
        lead_addr_c = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) lead_addr_c = addr[i*AW +: AW];
        end
    end

    assign found     = |pend;
    assign lead_addr = lead_addr_c;

    for (genvar g = 0; g < LANES; g++) begin : g_match
        assign grp_mask[g] = pend[g] && (addr[g*AW +: AW] == lead_addr_c);
    end

endmodule

// File: rtl/aco_result_store.sv
module aco_result_store #(
    parameter int LANES = 16,
    parameter int DW    = 32,
    parameter int CW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                we,
    input  logic [CW-1:0]       idx,
    input  logic [DW-1:0]       wdata,
    output logic [LANES-1:0]    rvld,
    output logic [LANES*DW-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rvld[g]             <= 1'b0;
                rdata[g*DW +: DW]   <= '0;
            end else if (clr) begin
                rvld[g]             <= 1'b0;
                rdata[g*DW +: DW]   <= '0;
            end else if (we && (idx == CW'(g))) begin
                rvld[g]             <= 1'b1;
                rdata[g*DW +: DW]   <= wdata;
            end
        end
    end

    // R9: a clear empties every slot on the next cycle
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rvld == '0));

    // R6: only a write can raise a valid bit
    a_r6_vld_rises_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr) |=> $stable(rvld));

endmodule

// File: rtl/atomic_coalescer.sv
module atomic_coalescer #(
    parameter int LANES = 16,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LANES-1:0]    lane_vld,
    input  logic [LANES-1:0]    lane_ret,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES*3-1:0]  lane_op,
    input  logic [LANES*DW-1:0] lane_opa,
    input  logic [LANES*DW-1:0] lane_opb,
    output logic                busy,
    output logic                mem_req_vld,
    input  logic                mem_req_rdy,
    output logic [AW-1:0]       mem_req_addr,
    output logic [LANES-1:0]    mem_req_mask,
    input  logic                mem_rsp_vld,
    input  logic [DW-1:0]       mem_rsp_data,
    output logic                wb_vld,
    output logic [AW-1:0]       wb_addr,
    output logic [DW-1:0]       wb_data,
    output logic                done,
    output logic [LANES-1:0]    res_vld,
    output logic [LANES*DW-1:0] res_data
);
    import aco_pkg::*;

    localparam int CW     = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int OPBITS = LANES * OPW;

    aco_state_e state_q, state_d;

    logic [LANES-1:0]    vld_q, ret_q, pend_q, grp_mask_q;
    logic [LANES*AW-1:0] addr_q;
    logic [OPBITS-1:0]   op_q;
    logic [LANES*DW-1:0] opa_q, opb_q;
    logic [AW-1:0]       grp_addr_q;
    logic [DW-1:0]       run_q;
    logic [CW-1:0]       cur_q;

    logic                pick_found;
    logic [AW-1:0]       pick_addr;
    logic [LANES-1:0]    pick_mask;
    logic [DW-1:0]       alu_new;
    logic                cur_last;
    logic                cur_hit;
    logic                capture, clr_res, st_we;

    aco_group_pick #(.LANES(LANES), .AW(AW)) u_pick (
        .pend      (pend_q),
        .addr      (addr_q),
        .found     (pick_found),
        .lead_addr (pick_addr),
        .grp_mask  (pick_mask)
    );

    aco_alu #(.DW(DW)) u_alu (
        .op      (op_q[cur_q*OPW +: OPW]),
        .old_val (run_q),
        .opa     (opa_q[cur_q*DW +: DW]),
        .opb     (opb_q[cur_q*DW +: DW]),
        .new_val (alu_new)
    );

    aco_result_store #(.LANES(LANES), .DW(DW), .CW(CW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_res),
        .we    (st_we),
        .idx   (cur_q),
        .wdata (run_q),
        .rvld  (res_vld),
        .rdata (res_data)
    );

    assign cur_last = (cur_q == CW'(LANES - 1));
    assign cur_hit  = grp_mask_q[cur_q];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_PICK;
            S_PICK:  state_d = pick_found ? S_REQ : S_DONE;
            S_REQ:   if (mem_req_rdy) state_d = S_WAIT;
            S_WAIT:  if (mem_rsp_vld) state_d = S_APPLY;
            S_APPLY: if (cur_last) state_d = S_WBACK;
            S_WBACK: state_d = S_PICK;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and controls, decoded from the state
    always_comb begin
        busy        = 1'b1;
        mem_req_vld = 1'b0;
        wb_vld      = 1'b0;
        done        = 1'b0;
        capture     = 1'b0;
        st_we       = 1'b0;
        unique case (state_q)
            S_IDLE:  begin busy = 1'b0; capture = start; end
            S_PICK:  ;
            S_REQ:   mem_req_vld = 1'b1;
            S_WAIT:  ;
            S_APPLY: st_we = cur_hit && ret_q[cur_q];
            S_WBACK: wb_vld = 1'b1;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign clr_res      = capture;
    assign mem_req_addr = grp_addr_q;
    assign mem_req_mask = grp_mask_q;
    assign wb_addr      = grp_addr_q;
    assign wb_data      = run_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q      <= '0;
            ret_q      <= '0;
            pend_q     <= '0;
            addr_q     <= '0;
            op_q       <= '0;
            opa_q      <= '0;
            opb_q      <= '0;
            grp_mask_q <= '0;
            grp_addr_q <= '0;
            run_q      <= '0;
            cur_q      <= '0;
        end else begin
            if (capture) begin
                vld_q  <= lane_vld;
                ret_q  <= lane_ret;
                pend_q <= lane_vld;
                addr_q <= lane_addr;
                op_q   <= lane_op;
                opa_q  <= lane_opa;
                opb_q  <= lane_opb;
            end
            if (state_q == S_PICK && pick_found) begin
                grp_mask_q <= pick_mask;
                grp_addr_q <= pick_addr;
                pend_q     <= pend_q & ~pick_mask;
            end
            if (state_q == S_WAIT && mem_rsp_vld) begin
                run_q <= mem_rsp_data;
                cur_q <= '0;
            end
            if (state_q == S_APPLY) begin
                if (cur_hit) run_q <= alu_new;
                cur_q <= cur_q + CW'(1);
            end
        end
    end

    // R2: request held steady until accepted
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_vld && !mem_req_rdy) |=>
            (mem_req_vld && $stable(mem_req_addr) && $stable(mem_req_mask)));

    // R1, R7: a request names at least one lane, and only valid ones
    a_r1_mask_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_vld |-> ((mem_req_mask != '0) && ((mem_req_mask & ~vld_q) == '0)));

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: request, write-back and done never overlap
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_vld, wb_vld, done}));

    // R6: results only for lanes that asked
    a_r6_res_only_asked: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((res_vld & ~(vld_q & ret_q)) == '0));

    // R2: no new request directly after a write-back
    a_r2_wb_then_pick: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |=> !mem_req_vld);

endmodule

// File: tb/atomic_coalescer_tb.sv
module atomic_coalescer_tb;
    localparam int L  = 16;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [L-1:0]    lane_vld = '0, lane_ret = '0;
    logic [L*AW-1:0] lane_addr = '0;
    logic [L*3-1:0]  lane_op = '0;
    logic [L*DW-1:0] lane_opa = '0, lane_opb = '0;
    logic busy, mem_req_vld, wb_vld, done;
    logic mem_req_rdy = 1'b0, mem_rsp_vld = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic [AW-1:0] mem_req_addr, wb_addr;
    logic [L-1:0]  mem_req_mask, res_vld;
    logic [DW-1:0] wb_data;
    logic [L*DW-1:0] res_data;

    always #10 clk = ~clk;

    atomic_coalescer #(.LANES(L), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .lane_vld(lane_vld), .lane_ret(lane_ret), .lane_addr(lane_addr),
        .lane_op(lane_op), .lane_opa(lane_opa), .lane_opb(lane_opb),
        .busy(busy), .mem_req_vld(mem_req_vld), .mem_req_rdy(mem_req_rdy),
        .mem_req_addr(mem_req_addr), .mem_req_mask(mem_req_mask),
        .mem_rsp_vld(mem_rsp_vld), .mem_rsp_data(mem_rsp_data),
        .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_data(wb_data),
        .done(done), .res_vld(res_vld), .res_data(res_data)
    );

    int checks = 0, errors = 0;
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] ref_mem [NW];
    logic          tv [L];
    logic          tr [L];
    logic [2:0]    ta [L];
    logic [2:0]    top [L];
    logic [DW-1:0] tx [L];
    logic [DW-1:0] ty [L];
    logic [DW-1:0] exp_res [L];
    logic [AW-1:0] exp_addr [L];
    logic [L-1:0]  exp_mask [L];
    int            exp_n;
    bit            hung = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_op(input logic [2:0] op, input logic [DW-1:0] o,
                                             input logic [DW-1:0] x, input logic [DW-1:0] y);
        case (op)
            3'd0: return o + x;
            3'd1: return (x < o) ? x : o;
            3'd2: return (x > o) ? x : o;
            3'd3: return x;
            3'd4: return (o == y) ? x : o;
            default: return o;
        endcase
    endfunction

    task automatic run_trial(input string name);
        logic [L-1:0] served;
        int k;
        int cyc;
        logic [AW-1:0] acc_addr;
        bit rsp_next;
        logic [L-1:0] res_vld_s;
        logic [L*DW-1:0] res_data_s;
        // expected values, sequential in lane order
        for (int w = 0; w < NW; w++) ref_mem[w] = mem[w];
        for (int i = 0; i < L; i++) begin
            exp_res[i] = '0;
            if (tv[i]) begin
                if (tr[i]) exp_res[i] = ref_mem[ta[i]];
                ref_mem[ta[i]] = ref_op(top[i], ref_mem[ta[i]], tx[i], ty[i]);
            end
        end
        served = '0;
        exp_n = 0;
        for (int i = 0; i < L; i++) begin
            if (tv[i] && !served[i]) begin
                exp_addr[exp_n] = AW'(ta[i]);
                exp_mask[exp_n] = '0;
                for (int j = 0; j < L; j++)
                    if (tv[j] && ta[j] == ta[i]) exp_mask[exp_n][j] = 1'b1;
                served |= exp_mask[exp_n];
                exp_n++;
            end
        end
        for (int i = 0; i < L; i++) begin
            lane_vld[i] = tv[i];
            lane_ret[i] = tr[i];
            lane_addr[i*AW +: AW] = AW'(ta[i]);
            lane_op[i*3 +: 3] = top[i];
            lane_opa[i*DW +: DW] = tx[i];
            lane_opb[i*DW +: DW] = ty[i];
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        k = 0; cyc = 0; rsp_next = 0; acc_addr = '0;
        forever begin
            if (done) break;
            if (cyc > 3000) begin
                chk(0, "R8", {name, " timeout"}, 0, 1);
                hung = 1;
                break;
            end
            if (mem_rsp_vld) mem_rsp_vld = 1'b0;
            if (rsp_next) begin
                mem_req_rdy = 1'b0;
                mem_rsp_vld = 1'b1;
                mem_rsp_data = mem[acc_addr[2:0]];
                rsp_next = 0;
            end else if (mem_req_vld) begin
                // R1 R2: request matches the expected group in order
                chk(k < exp_n, "R1", {name, " extra request"}, 64'(k), 64'(exp_n));
                if (k < exp_n) begin
                    chk(mem_req_addr == exp_addr[k], "R2", {name, " req addr"},
                        64'(mem_req_addr), 64'(exp_addr[k]));
                    chk(mem_req_mask == exp_mask[k], "R1", {name, " req mask"},
                        64'(mem_req_mask), 64'(exp_mask[k]));
                end
                acc_addr = mem_req_addr;
                mem_req_rdy = 1'b1;
                rsp_next = 1;
                k++;
            end
            if (wb_vld) begin
                chk(wb_addr == acc_addr, "R5", {name, " wb addr"}, 64'(wb_addr), 64'(acc_addr));
                mem[wb_addr[2:0]] = wb_data;
            end
            @(negedge clk);
            cyc++;
        end
        if (hung) return;
        chk(k == exp_n, "R1", {name, " request count"}, 64'(k), 64'(exp_n));
        for (int i = 0; i < L; i++) begin
            chk(res_vld[i] == (tv[i] && tr[i]), (tv[i] ? "R6" : "R7"), {name, " res_vld"},
                64'(res_vld[i]), 64'(tv[i] && tr[i]));
            chk(res_data[i*DW +: DW] == exp_res[i], "R3", {name, " res_data"},
                64'(res_data[i*DW +: DW]), 64'(exp_res[i]));
        end
        for (int w = 0; w < NW; w++)
            chk(mem[w] == ref_mem[w], "R5", {name, " final word"}, 64'(mem[w]), 64'(ref_mem[w]));
        res_vld_s = res_vld;
        res_data_s = res_data;
        @(negedge clk);
        chk(!done, "R8", {name, " done pulse"}, 64'(done), 0);
        chk(res_vld == res_vld_s && res_data == res_data_s, "R8", {name, " results hold"},
            64'(res_vld), 64'(res_vld_s));
    endtask

    task automatic clear_lanes();
        for (int i = 0; i < L; i++) begin
            tv[i] = 0; tr[i] = 0; ta[i] = 0; top[i] = 0; tx[i] = 0; ty[i] = 0;
        end
    endtask

    initial begin
        #(20 * 190000);
        chk(0, "R8", "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) mem[w] = 32'h100 * (w + 1);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!busy && !mem_req_vld && !wb_vld && !done, "R9", "idle outputs",
            64'({busy, mem_req_vld, wb_vld, done}), 0);
        chk(res_vld == '0, "R9", "res_vld cleared", 64'(res_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req_vld, "R9", "idle after release", 64'({busy, mem_req_vld}), 0);

        // R3: all lanes add to one word
        clear_lanes();
        for (int i = 0; i < L; i++) begin tv[i] = 1; tr[i] = 1; ta[i] = 3; tx[i] = i + 1; end
        run_trial("R3 add chain");

        // R1: all distinct addresses (8 words, two passes over lanes)
        clear_lanes();
        for (int i = 0; i < L; i++) begin
            tv[i] = 1; tr[i] = 1; ta[i] = 3'(7 - (i % 8)); top[i] = 3'(i % 4); tx[i] = 32'(i * 37);
        end
        run_trial("R1 spread");

        // R4: compare-swap chain
        clear_lanes();
        mem[2] = 5;
        tv[0] = 1; tr[0] = 1; ta[0] = 2; top[0] = 4; ty[0] = 5; tx[0] = 6;
        tv[1] = 1; tr[1] = 1; ta[1] = 2; top[1] = 4; ty[1] = 5; tx[1] = 7;
        tv[2] = 1; tr[2] = 1; ta[2] = 2; top[2] = 4; ty[2] = 6; tx[2] = 9;
        tv[3] = 1; tr[3] = 1; ta[3] = 2; top[3] = 3; tx[3] = 1;
        tv[4] = 1; tr[4] = 1; ta[4] = 2; top[4] = 6; tx[4] = 77;
        run_trial("R4 cas chain");
        chk(mem[2] == 1, "R4", "cas chain final", 64'(mem[2]), 1);

        // R6: lanes without return flag
        clear_lanes();
        for (int i = 0; i < L; i++) begin tv[i] = 1; tr[i] = i[0]; ta[i] = 3'(i % 2); tx[i] = 3; end
        run_trial("R6 no-ret");

        // R7 R8: no valid lanes
        clear_lanes();
        for (int i = 0; i < L; i++) begin tr[i] = 1; tx[i] = 99; end
        run_trial("R8 empty");

        // R7: sparse valid lanes
        clear_lanes();
        for (int i = 0; i < L; i += 3) begin tv[i] = 1; tr[i] = 1; ta[i] = 1; top[i] = 2; tx[i] = 32'(i * 1000); end
        tr[2] = 1; ta[2] = 1; tx[2] = 32'hFFFF_FFFF; top[2] = 3;
        run_trial("R7 sparse");

        // R3 R4: random sweep with crowded addresses
        for (int t = 0; t < 180 && !hung; t++) begin
            for (int i = 0; i < L; i++) begin
                tv[i] = ($urandom % 5) != 0;
                tr[i] = ($urandom % 4) != 0;
                ta[i] = 3'($urandom % ((t % 3 == 0) ? 2 : 4) + (t % 4));
                top[i] = 3'($urandom % 8);
                tx[i] = ($urandom % 3 == 0) ? $urandom : 32'($urandom % 8);
                ty[i] = 32'($urandom % 8);
            end
            if (t % 7 == 0) for (int w = 0; w < NW; w++) mem[w] = 32'($urandom % 8);
            run_trial("R4 sweep");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule